// File: doc/BRIEF.md
# Serial Receive Queue with Trigger and Idle Flags

This block is the receive-side byte queue of a serial controller. On each frame tick it can take in one byte. The byte comes from the line-side deserialiser, or, when loopback is selected, from the transmit side. Bytes are held in a 16-entry first-in first-out store. A CPU read port shows the oldest byte and removes it on request. The current fill level is exported continuously for a data-count register.

Three status flags are maintained:

- **Receive-full** rises when the fill level reaches a programmable trigger, chosen from a small non-linear set.
- **Data-ready** rises when a partial batch below the trigger has sat untouched for two consecutive frame ticks.
- **Overrun** is a sticky error. It is set when a byte arrives while the queue holds 16 bytes, and it stops all further reception until it is explicitly cleared.

Two level interrupt requests, one for receive and one for error, are formed from these flags and their enables. A queue-reset input empties the store and drops the receive flags.

Top module: `serial_rx_queue`

## Requirements
- R1: The queue stores up to 16 bytes in arrival order, and `rx_count` always equals the number of bytes held (0 to 16). After reset `rx_count` is 0 and all flags and interrupt outputs are 0.
- R2: On a cycle with `tick`=1 and reception live, the byte is enqueued if one is offered. The offered byte is `line_data` with `line_valid` when `loop_en`=0, and `tx_data` with `tx_valid` when `loop_en`=1. The deselected source has no effect.
- R3: `trig_code` selects the trigger level: 0 means 1 byte, 1 means 4, 2 means 8 and 3 means 14. Code 0 is the default, so holding the input at 0 gives a trigger of 1.
- R4: `full_flag` is 1 in the cycle after an enqueue that leaves the count greater than or equal to the trigger.
- R5: At a tick with no byte received in that tick or in the previous tick, `ready_flag` sets if the count after the cycle is non-zero and below the trigger.
- R6: A byte offered while the count is 16 is discarded and sets `overrun_flag`. The flag stays set until `ovr_clr`. While it is set no byte is taken in, even with `rx_en`=1.
- R7: `err_irq` is 1 exactly when `overrun_flag` is 1 and at least one of `rx_irq_en` and `err_irq_en` is 1.
- R8: `rd_data` shows the oldest byte, and `rd_req` removes it. With `rd_clear`=1 the read clears `full_flag` if the count after the read is below the trigger, and clears `ready_flag` if that count is 0. With `rd_clear`=0 the flags are left unchanged.
- R9: On an empty queue `rd_data` reads 0, and `rd_req` changes no count or flag.
- R10: `fifo_clr` empties the queue and clears `full_flag` and `ready_flag`. Any byte offered in the same cycle is discarded, and `overrun_flag` is left as it was.
- R11: `rx_irq` is the level `rx_irq_en` AND (`full_flag` OR `ready_flag`).
- R12: With `rx_en`=0, offered bytes are not enqueued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Frame tick; at most one byte is taken in per tick |
| loop_en | input | 1 | 1 selects the transmit side as the byte source |
| line_valid | input | 1 | A line-side byte is available |
| line_data | input | 8 | Line-side byte |
| tx_valid | input | 1 | A transmit-side byte is available (loopback) |
| tx_data | input | 8 | Transmit-side byte |
| rx_en | input | 1 | Receive enable |
| rx_irq_en | input | 1 | Receive interrupt enable |
| err_irq_en | input | 1 | Error interrupt enable |
| trig_code | input | 2 | Trigger level select |
| fifo_clr | input | 1 | Queue reset |
| ovr_clr | input | 1 | Clears the overrun flag |
| rd_req | input | 1 | CPU read: dequeue the oldest byte |
| rd_clear | input | 1 | The read also updates the receive flags |
| rd_data | output | 8 | Oldest byte, or 0 when empty |
| rx_count | output | 5 | Number of bytes held |
| full_flag | output | 1 | Receive-full flag |
| ready_flag | output | 1 | Data-ready (idle partial batch) flag |
| overrun_flag | output | 1 | Sticky overrun error |
| rx_irq | output | 1 | Receive interrupt request (level) |
| err_irq | output | 1 | Error interrupt request (level) |

## Verification
The data-ready flag is the hardest behaviour to reach, because it depends on two consecutive ticks without a received byte while a partial batch sits below the trigger. The stimulus produces this state by first loading bytes with ticks and draining the count below a trigger of 4 without ticks. It then issues one empty tick, at which the flag must stay low, and a second empty tick, at which it must rise. Overrun is reached by filling all 16 entries and offering a seventeenth byte. After that, a read frees space and a further offered byte shows that reception stays blocked until the flag is cleared. Each trigger code is swept over a full fill and drain, so the flag edges land at every level.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    parameter int unsigned RXQ_DEPTH = 16;
    parameter int unsigned RXQ_DW    = 8;

    typedef enum logic [1:0] {
        TRG_ONE     = 2'd0,
        TRG_FOUR    = 2'd1,
        TRG_EIGHT   = 2'd2,
        TRG_FOURTEEN = 2'd3
    } trig_code_e;

    typedef struct packed {
        logic full;
        logic ready;
        logic ovr;
    } rxq_flags_t;

    typedef struct packed {
        logic push;
        logic pop;
        logic clr;
    } rxq_op_t;

    // Receive trigger level in bytes for a 2-bit code
    function automatic int unsigned trig_level(input logic [1:0] code);
        trig_code_e c;
        c = trig_code_e'(code);
        case (c)
            TRG_ONE:     return 1;
            TRG_FOUR:    return 4;
            TRG_EIGHT:   return 8;
            default:     return 14;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import serial_rx_pkg::*;
#(
    parameter int unsigned DEPTH = RXQ_DEPTH,
    parameter int unsigned DW    = RXQ_DW,
    localparam int unsigned CW   = $clog2(DEPTH + 1),
    localparam int unsigned PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  rxq_op_t       op,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_nx
);

    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == LAST_PTR) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        if (op.clr)
            count_nx = '0;
        else
            count_nx = count + CW'(op.push) - CW'(op.pop);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            count <= count_nx;
            if (op.clr) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (op.push) wr_ptr <= bump(wr_ptr);
                if (op.pop)  rd_ptr <= bump(rd_ptr);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (op.push && !op.clr)
            mem[wr_ptr] <= wdata;
    end

    assign rdata = mem[rd_ptr];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        op.push |-> count != FULL_CNT);                               // R1
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        op.pop |-> count != '0);                                      // R9
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT);                                           // R1

endmodule

// File: rtl/rxq_status.sv
module rxq_status
    import serial_rx_pkg::*;
#(
    parameter int unsigned DEPTH = RXQ_DEPTH,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          rcvd,
    input  rxq_op_t       op,
    input  logic          ovr_hit,
    input  logic          ovr_clr,
    input  logic          pop_clear,
    input  logic [CW-1:0] count_nx,
    input  logic [CW-1:0] trig,
    output rxq_flags_t    flags
);

    logic rcvd_prev;
    logic ready_set;

    // Partial batch idle for this tick and the one before
    assign ready_set = tick && !rcvd && !rcvd_prev &&
                       (count_nx != '0) && (count_nx < trig);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags     <= '0;
            rcvd_prev <= 1'b0;
        end else begin
            if (tick)
                rcvd_prev <= rcvd;

            if (ovr_hit)
                flags.ovr <= 1'b1;
            else if (ovr_clr)
                flags.ovr <= 1'b0;

            if (op.clr) begin
                flags.full  <= 1'b0;
                flags.ready <= 1'b0;
            end else begin
                if (op.push && count_nx >= trig)
                    flags.full <= 1'b1;
                else if (pop_clear && count_nx < trig)
                    flags.full <= 1'b0;

                if (ready_set)
                    flags.ready <= 1'b1;
                else if (pop_clear && count_nx == '0)
                    flags.ready <= 1'b0;
            end
        end
    end

    AST_FULL_ON_TRIGGER: assert property (@(posedge clk) disable iff (rst)
        (op.push && !op.clr && count_nx >= trig) |=> flags.full);     // R4
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flags.ovr && !ovr_clr) |=> flags.ovr);                       // R6
    AST_CLR_DROPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        op.clr |=> (!flags.full && !flags.ready));                    // R10

endmodule

// File: rtl/rxq_irq.sv
module rxq_irq
    import serial_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  rxq_flags_t flags,
    input  logic       rx_irq_en,
    input  logic       err_irq_en,
    output logic       rx_irq,
    output logic       err_irq
);

    always_comb begin
        rx_irq  = rx_irq_en && (flags.full || flags.ready);
        err_irq = (rx_irq_en || err_irq_en) && flags.ovr;
    end

    AST_ERR_ON_OVR_RISE: assert property (@(posedge clk) disable iff (rst)
        ($rose(flags.ovr) && (rx_irq_en || err_irq_en)) |-> err_irq); // R7
    AST_RX_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> (flags.full || flags.ready));                      // R11

endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
    import serial_rx_pkg::*;
#(
    parameter int unsigned DEPTH = RXQ_DEPTH,
    parameter int unsigned DW    = RXQ_DW,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          loop_en,
    input  logic          line_valid,
    input  logic [DW-1:0] line_data,
    input  logic          tx_valid,
    input  logic [DW-1:0] tx_data,
    input  logic          rx_en,
    input  logic          rx_irq_en,
    input  logic          err_irq_en,
    input  logic [1:0]    trig_code,
    input  logic          fifo_clr,
    input  logic          ovr_clr,
    input  logic          rd_req,
    input  logic          rd_clear,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] rx_count,
    output logic          full_flag,
    output logic          ready_flag,
    output logic          overrun_flag,
    output logic          rx_irq,
    output logic          err_irq
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    rxq_flags_t    flags;
    rxq_op_t       op;
    logic [CW-1:0] count;
    logic [CW-1:0] count_nx;
    logic [CW-1:0] trig;
    logic [DW-1:0] head;
    logic [DW-1:0] src_data;
    logic          src_valid;
    logic          live;
    logic          offer;
    logic          ovr_hit;
    logic          pop_clear;

    always_comb begin
        live      = rx_en && !flags.ovr;
        src_valid = loop_en ? tx_valid : line_valid;
        src_data  = loop_en ? tx_data  : line_data;
        offer     = tick && src_valid && live && !fifo_clr;
        trig      = CW'(trig_level(trig_code));

        op.clr    = fifo_clr;
        op.push   = offer && (count != FULL_CNT);
        op.pop    = rd_req && (count != '0) && !fifo_clr;
        ovr_hit   = offer && (count == FULL_CNT);
        pop_clear = op.pop && rd_clear;
    end

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .wdata    (src_data),
        .rdata    (head),
        .count    (count),
        .count_nx (count_nx)
    );

    rxq_status #(.DEPTH(DEPTH)) u_status (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .rcvd      (offer),
        .op        (op),
        .ovr_hit   (ovr_hit),
        .ovr_clr   (ovr_clr),
        .pop_clear (pop_clear),
        .count_nx  (count_nx),
        .trig      (trig),
        .flags     (flags)
    );

    rxq_irq u_irq (
        .clk        (clk),
        .rst        (rst),
        .flags      (flags),
        .rx_irq_en  (rx_irq_en),
        .err_irq_en (err_irq_en),
        .rx_irq     (rx_irq),
        .err_irq    (err_irq)
    );

    assign rd_data      = (count != '0) ? head : '0;
    assign rx_count     = count;
    assign full_flag    = flags.full;
    assign ready_flag   = flags.ready;
    assign overrun_flag = flags.ovr;

    AST_READY_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_flag) |-> rx_count != '0);                        // R5
    AST_BLOCKED_RX: assert property (@(posedge clk) disable iff (rst)
        ((!rx_en || overrun_flag) && !rd_req && !fifo_clr) |=> $stable(rx_count)); // R12
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rx_count == '0) |-> (rd_data == '0));                        // R9

endmodule

// File: tb/sim_serial_rx_queue.sv
module sim_serial_rx_queue;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 0, loop_en = 0, line_valid = 0, tx_valid = 0;
    logic [7:0] line_data = 0, tx_data = 0;
    logic       rx_en = 1, rx_irq_en = 1, err_irq_en = 0;
    logic [1:0] trig_code = 0;
    logic       fifo_clr = 0, ovr_clr = 0, rd_req = 0, rd_clear = 0;
    logic [7:0] rd_data;
    logic [4:0] rx_count;
    logic       full_flag, ready_flag, overrun_flag, rx_irq, err_irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    serial_rx_queue u0 (
        .clk(clk), .rst(rst), .tick(tick), .loop_en(loop_en),
        .line_valid(line_valid), .line_data(line_data),
        .tx_valid(tx_valid), .tx_data(tx_data), .rx_en(rx_en),
        .rx_irq_en(rx_irq_en), .err_irq_en(err_irq_en), .trig_code(trig_code),
        .fifo_clr(fifo_clr), .ovr_clr(ovr_clr), .rd_req(rd_req),
        .rd_clear(rd_clear), .rd_data(rd_data), .rx_count(rx_count),
        .full_flag(full_flag), .ready_flag(ready_flag),
        .overrun_flag(overrun_flag), .rx_irq(rx_irq), .err_irq(err_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic int trig_of(input int s);
        return (s == 0) ? 1 : (s == 3) ? 14 : (4 << (s - 1));
    endfunction

    task automatic line_byte(input logic [7:0] d);
        tick = 1; line_valid = 1; line_data = d;
        step();
        tick = 0; line_valid = 0;
    endtask

    task automatic read_one(input logic clr);
        rd_req = 1; rd_clear = clr;
        step();
        rd_req = 0; rd_clear = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
        end
    end

    initial begin
        repeat (3) step();
        rst = 0;
        // R1 reset state
        chk("R1 reset count", rx_count, 0);
        chk("R11 reset rx_irq", rx_irq, 0);
        chk("R6 reset overrun", overrun_flag, 0);

        // R3 R4 R1 R8 sweep of every trigger code over full fill and drain
        for (int s = 0; s < 4; s++) begin
            int tl;
            tl = trig_of(s);
            trig_code = 2'(s);
            for (int k = 1; k <= 16; k++) begin
                line_byte(8'(s * 16 + k));
                chk("R1 count on fill", rx_count, k);
                chk("R3 R4 full on fill", full_flag, int'(k >= tl));
                chk("R11 rx_irq on fill", rx_irq, int'(k >= tl));
            end
            for (int k = 1; k <= 16; k++) begin
                chk("R8 head byte", rd_data, (s * 16 + k) & 8'hff);
                read_one(1);
                chk("R8 count on drain", rx_count, 16 - k);
                chk("R8 full on drain", full_flag, int'((16 - k) >= tl));
                chk("R5 no ready while streaming", ready_flag, 0);
            end
        end

        // R8 read without flag clearing, then R5 idle data-ready
        trig_code = 2'd1;
        for (int k = 0; k < 5; k++) line_byte(8'(100 + k));
        chk("R4 full at 5 of 4", full_flag, 1);
        for (int k = 0; k < 3; k++) read_one(0);
        chk("R8 count after plain reads", rx_count, 2);
        chk("R8 full kept without rd_clear", full_flag, 1);
        read_one(1);
        chk("R8 full cleared below trigger", full_flag, 0);
        tick = 1; step(); tick = 0;
        chk("R5 no ready one tick after byte", ready_flag, 0);
        rx_irq_en = 0;
        tick = 1; step(); tick = 0;
        chk("R5 ready after two idle ticks", ready_flag, 1);
        chk("R11 rx_irq gated off", rx_irq, 0);
        rx_irq_en = 1; #1;
        chk("R11 rx_irq from ready", rx_irq, 1);
        read_one(1);
        chk("R8 ready cleared at empty", ready_flag, 0);
        chk("R11 rx_irq dropped", rx_irq, 0);

        // R9 empty read
        chk("R9 empty rd_data", rd_data, 0);
        read_one(1);
        chk("R9 count stays 0", rx_count, 0);
        chk("R9 flags unchanged", {full_flag, ready_flag, overrun_flag}, 0);

        // R2 loopback source selection
        loop_en = 1; tx_valid = 1; tx_data = 8'hA5; line_valid = 1; line_data = 8'h3C;
        tick = 1; step(); tick = 0;
        chk("R2 loopback count", rx_count, 1);
        chk("R2 loopback byte", rd_data, 8'hA5);
        loop_en = 0; line_valid = 0;
        tick = 1; step(); tick = 0; tx_valid = 0;
        chk("R2 tx ignored without loopback", rx_count, 1);
        fifo_clr = 1; step(); fifo_clr = 0;
        chk("R10 clear empties", rx_count, 0);

        // R12 receive disabled
        rx_en = 0;
        line_byte(8'h11);
        chk("R12 no enqueue when disabled", rx_count, 0);
        rx_en = 1;

        // R6 R7 overrun
        trig_code = 2'd0; rx_irq_en = 0; err_irq_en = 1;
        for (int k = 0; k < 16; k++) line_byte(8'(k));
        chk("R1 full capacity", rx_count, 16);
        line_byte(8'hEE);
        chk("R6 overrun set", overrun_flag, 1);
        chk("R6 byte discarded", rx_count, 16);
        chk("R7 err_irq via error enable", err_irq, 1);
        err_irq_en = 0; #1;
        chk("R7 err_irq both enables off", err_irq, 0);
        rx_irq_en = 1; #1;
        chk("R7 err_irq via receive enable", err_irq, 1);
        read_one(0);
        line_byte(8'h55);
        chk("R6 reception blocked", rx_count, 15);
        ovr_clr = 1; step(); ovr_clr = 0;
        chk("R6 overrun cleared", overrun_flag, 0);
        chk("R7 err_irq low", err_irq, 0);
        line_byte(8'h77);
        chk("R6 reception resumes", rx_count, 16);
        chk("R1 order kept", rd_data, 1);
        line_byte(8'h88);
        chk("R6 second overrun", overrun_flag, 1);

        // R10 queue reset
        fifo_clr = 1; step(); fifo_clr = 0;
        chk("R10 count zero", rx_count, 0);
        chk("R10 full cleared", full_flag, 0);
        chk("R10 overrun kept", overrun_flag, 1);
        ovr_clr = 1; step(); ovr_clr = 0;
        fifo_clr = 1; tick = 1; line_valid = 1; line_data = 8'h42;
        step();
        fifo_clr = 0; tick = 0; line_valid = 0;
        chk("R10 same-cycle byte discarded", rx_count, 0);
        chk("R10 no ready/full", {full_flag, ready_flag}, 0);

        done = 1;
        summary();
    end

endmodule